// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a two-part logical address, a segment number plus an offset inside that segment, into a linear physical address. A small table held in flops describes each segment. Each entry has a starting physical address (base), a length (limit), a valid bit and three permission bits for read, write and execute. A length register sets how many segments are currently legal.

Each translation request carries a segment number, an offset and an access type. The unit runs four checks in a fixed priority order: segment number against the length register, then the entry's valid bit, then the access permission, then the offset against the limit. One cycle later it returns either the physical address (base plus offset) or the code of the highest-priority failed check.

A configuration write port loads entries and the length register. A write takes effect only while the privileged-mode input is high. A write attempted in user mode is discarded and flagged.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `rsp_valid_o`, `rsp_fault_o`, `rsp_paddr_o` and `cfg_illegal_o` are 0. The length register is 0 and every entry is invalid, so any request before configuration faults with code 1.
- R2: A request presented with `req_valid_i` high at a rising edge is answered on the outputs right after that edge. In any cycle without a response, `rsp_valid_o` is 0 and fault and address are 0.
- R3: A request whose segment number is greater than or equal to the length register returns fault code 1. This check outranks all others.
- R4: A request to a legal segment whose entry valid bit is 0 returns fault code 2. This outranks the permission and limit checks.
- R5: Permission bits are bit 0 read, bit 1 write and bit 2 execute. Access codes are 0 read, 1 write, 2 execute; code 3 is never permitted. An access to a valid entry whose permission bit is clear returns fault code 3, and this outranks the limit check.
- R6: An otherwise allowed access whose offset is greater than or equal to the entry limit returns fault code 4. A limit of 0 makes every offset fault.
- R7: An access that passes all checks returns fault code 0 and a 17-bit physical address equal to base plus offset, with no truncation of the carry.
- R8: Any faulting response returns physical address 0.
- R9: A write with `cfg_we_i` and `cfg_priv_i` high stores either the length register (`cfg_len_sel_i`=1) or the entry at `cfg_idx_i` (`cfg_len_sel_i`=0). Requests from the next cycle on see the new contents.
- R10: A write with `cfg_priv_i` low changes neither the table nor the length register. `cfg_illegal_o` is high for exactly the cycle that follows such a write, and low otherwise.
- R11: A request in the same cycle as a privileged write is translated with the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_priv_i | input | 1 | Privileged mode; writes are accepted only when high |
| cfg_len_sel_i | input | 1 | 1: write the length register, 0: write a table entry |
| cfg_idx_i | input | 4 | Entry index for an entry write |
| cfg_base_i | input | 16 | Base to store |
| cfg_limit_i | input | 13 | Segment length to store (0 to 4096) |
| cfg_valid_i | input | 1 | Valid bit to store |
| cfg_perm_i | input | 3 | Permission bits to store (bit 0 read, 1 write, 2 execute) |
| cfg_len_i | input | 5 | Length register value to store |
| cfg_illegal_o | output | 1 | Pulses the cycle after a dropped user-mode write |
| req_valid_i | input | 1 | Translation request strobe |
| req_seg_i | input | 4 | Segment number |
| req_off_i | input | 12 | Offset within the segment |
| req_acc_i | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_fault_o | output | 3 | 0 ok, 1 segment range, 2 invalid, 3 access, 4 limit |
| rsp_paddr_o | output | 17 | Physical address, 0 on a fault |

## Verification
The assertions check several properties on every cycle:
- a response only follows a request;
- a fault never carries an address;
- a segment at or beyond the length register always reports the range fault;
- a success or limit fault agrees with the entry's limit and valid bit;
- a user-mode write leaves the length register unchanged and raises the flag exactly once.

Other behaviour can only be shown by the bench's scenarios:
- the full priority ordering when several checks fail together;
- carry-out in base plus offset;
- old contents being used in the cycle of a write;
- table entries, not only the length register, being untouched by a dropped write.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned SEG_W_DEF  = 4;
  localparam int unsigned OFF_W_DEF  = 12;
  localparam int unsigned BASE_W_DEF = 16;

  localparam int unsigned PERM_RD = 0;
  localparam int unsigned PERM_WR = 1;
  localparam int unsigned PERM_EX = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  // order of codes follows check priority
  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_SEG_RANGE = 3'd1,
    FLT_INVALID   = 3'd2,
    FLT_ACCESS    = 3'd3,
    FLT_LIMIT     = 3'd4
  } fault_e;
endpackage

// File: rtl/seg_entry_reg.sv
module seg_entry_reg #(
  parameter int unsigned BASE_W = 16,
  parameter int unsigned LIM_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              valid_i,
  input  logic [2:0]        perm_i,
  output logic [BASE_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic              valid_o,
  output logic [2:0]        perm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      limit_o <= '0;
      valid_o <= 1'b0;
      perm_o  <= '0;
    end else if (we_i) begin
      base_o  <= base_i;
      limit_o <= limit_i;
      valid_o <= valid_i;
      perm_o  <= perm_i;
    end
  end
endmodule

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned BASE_W = 16,
  parameter int unsigned LIM_W  = 13,
  localparam int unsigned N_SEG = 1 << SEG_W,
  localparam int unsigned LEN_W = SEG_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_priv_i,
  input  logic              cfg_len_sel_i,
  input  logic [SEG_W-1:0]  cfg_idx_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [LIM_W-1:0]  cfg_limit_i,
  input  logic              cfg_valid_i,
  input  logic [2:0]        cfg_perm_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  output logic              illegal_o,
  input  logic [SEG_W-1:0]  rd_idx_i,
  output logic [BASE_W-1:0] rd_base_o,
  output logic [LIM_W-1:0]  rd_limit_o,
  output logic              rd_valid_o,
  output logic [2:0]        rd_perm_o,
  output logic [LEN_W-1:0]  len_o
);
  logic              wr_ok;
  logic              wr_drop;
  logic [BASE_W-1:0] base_a  [N_SEG];
  logic [LIM_W-1:0]  limit_a [N_SEG];
  logic              valid_a [N_SEG];
  logic [2:0]        perm_a  [N_SEG];
  logic [LEN_W-1:0]  len_q;
  logic              illegal_q;

  assign wr_ok   = cfg_we_i & cfg_priv_i;
  assign wr_drop = cfg_we_i & ~cfg_priv_i;

  for (genvar g = 0; g < N_SEG; g++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_ok & ~cfg_len_sel_i & (cfg_idx_i == SEG_W'(g));
    seg_entry_reg #(.BASE_W(BASE_W), .LIM_W(LIM_W)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ent_we),
      .base_i  (cfg_base_i),
      .limit_i (cfg_limit_i),
      .valid_i (cfg_valid_i),
      .perm_i  (cfg_perm_i),
      .base_o  (base_a[g]),
      .limit_o (limit_a[g]),
      .valid_o (valid_a[g]),
      .perm_o  (perm_a[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (wr_ok && cfg_len_sel_i) len_q <= cfg_len_i;
      illegal_q <= wr_drop;
    end
  end

  // read port sees pre-write contents in the cycle of a write
  assign rd_base_o  = base_a[rd_idx_i];
  assign rd_limit_o = limit_a[rd_idx_i];
  assign rd_valid_o = valid_a[rd_idx_i];
  assign rd_perm_o  = perm_a[rd_idx_i];
  assign len_o      = len_q;
  assign illegal_o  = illegal_q;

  assert_user_write_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_priv_i) |=> ($stable(len_q) && illegal_o));

  assert_illegal_only_after_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(cfg_we_i && !cfg_priv_i));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned BASE_W = 16,
  localparam int unsigned LIM_W = OFF_W + 1,
  localparam int unsigned LEN_W = SEG_W + 1,
  localparam int unsigned PA_W  = BASE_W + 1
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        acc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              valid_i,
  input  logic [2:0]        perm_i,
  output fault_e            fault_o,
  output logic [PA_W-1:0]   paddr_o
);
  logic perm_ok;
  logic seg_oob;
  logic off_oob;

  always_comb begin
    unique case (access_e'(acc_i))
      ACC_READ:  perm_ok = perm_i[PERM_RD];
      ACC_WRITE: perm_ok = perm_i[PERM_WR];
      ACC_EXEC:  perm_ok = perm_i[PERM_EX];
      default:   perm_ok = 1'b0;
    endcase
  end

  assign seg_oob = LEN_W'(seg_i) >= len_i;
  assign off_oob = LIM_W'(off_i) >= limit_i;

  always_comb begin
    if (seg_oob)       fault_o = FLT_SEG_RANGE;
    else if (!valid_i) fault_o = FLT_INVALID;
    else if (!perm_ok) fault_o = FLT_ACCESS;
    else if (off_oob)  fault_o = FLT_LIMIT;
    else               fault_o = FLT_NONE;
  end

  assign paddr_o = (fault_o == FLT_NONE) ? (PA_W'(base_i) + PA_W'(off_i)) : '0;
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W = 17
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  fault_e          fault_i,
  input  logic [PA_W-1:0] paddr_i,
  output logic            valid_o,
  output logic [2:0]      fault_o,
  output logic [PA_W-1:0] paddr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= '0;
      paddr_o <= '0;
    end else begin
      valid_o <= valid_i;
      fault_o <= valid_i ? fault_i : FLT_NONE;
      paddr_o <= valid_i ? paddr_i : '0;
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  assert_fault_no_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o != 3'd0) |-> (paddr_o == '0));
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W  = SEG_W_DEF,
  parameter int unsigned OFF_W  = OFF_W_DEF,
  parameter int unsigned BASE_W = BASE_W_DEF,
  localparam int unsigned LIM_W = OFF_W + 1,
  localparam int unsigned LEN_W = SEG_W + 1,
  localparam int unsigned PA_W  = BASE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_priv_i,
  input  logic              cfg_len_sel_i,
  input  logic [SEG_W-1:0]  cfg_idx_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [LIM_W-1:0]  cfg_limit_i,
  input  logic              cfg_valid_i,
  input  logic [2:0]        cfg_perm_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  output logic              cfg_illegal_o,
  input  logic              req_valid_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [1:0]        req_acc_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_fault_o,
  output logic [PA_W-1:0]   rsp_paddr_o
);
  logic [BASE_W-1:0] rd_base;
  logic [LIM_W-1:0]  rd_limit;
  logic              rd_valid;
  logic [2:0]        rd_perm;
  logic [LEN_W-1:0]  len;
  fault_e            flt;
  logic [PA_W-1:0]   paddr;

  seg_table #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_table (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_priv_i    (cfg_priv_i),
    .cfg_len_sel_i (cfg_len_sel_i),
    .cfg_idx_i     (cfg_idx_i),
    .cfg_base_i    (cfg_base_i),
    .cfg_limit_i   (cfg_limit_i),
    .cfg_valid_i   (cfg_valid_i),
    .cfg_perm_i    (cfg_perm_i),
    .cfg_len_i     (cfg_len_i),
    .illegal_o     (cfg_illegal_o),
    .rd_idx_i      (req_seg_i),
    .rd_base_o     (rd_base),
    .rd_limit_o    (rd_limit),
    .rd_valid_o    (rd_valid),
    .rd_perm_o     (rd_perm),
    .len_o         (len)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_check (
    .seg_i   (req_seg_i),
    .off_i   (req_off_i),
    .acc_i   (req_acc_i),
    .len_i   (len),
    .base_i  (rd_base),
    .limit_i (rd_limit),
    .valid_i (rd_valid),
    .perm_i  (rd_perm),
    .fault_o (flt),
    .paddr_o (paddr)
  );

  seg_rsp_reg #(.PA_W(PA_W)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .fault_i (flt),
    .paddr_i (paddr),
    .valid_o (rsp_valid_o),
    .fault_o (rsp_fault_o),
    .paddr_o (rsp_paddr_o)
  );

  assert_range_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (LEN_W'(req_seg_i) >= len)) |-> (flt == FLT_SEG_RANGE));

  assert_ok_in_bounds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && flt == FLT_NONE) |-> (rd_valid && (LIM_W'(req_off_i) < rd_limit)));

  assert_limit_fault_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && flt == FLT_LIMIT) |-> (LIM_W'(req_off_i) >= rd_limit));

  assert_invalid_fault_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && flt == FLT_INVALID) |-> !rd_valid);
endmodule

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 0, cfg_priv_i = 0, cfg_len_sel_i = 0;
  logic [3:0]  cfg_idx_i = 0;
  logic [15:0] cfg_base_i = 0;
  logic [12:0] cfg_limit_i = 0;
  logic        cfg_valid_i = 0;
  logic [2:0]  cfg_perm_i = 0;
  logic [4:0]  cfg_len_i = 0;
  logic        cfg_illegal_o;
  logic        req_valid_i = 0;
  logic [3:0]  req_seg_i = 0;
  logic [11:0] req_off_i = 0;
  logic [1:0]  req_acc_i = 0;
  logic        rsp_valid_o;
  logic [2:0]  rsp_fault_o;
  logic [16:0] rsp_paddr_o;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  int unsigned m_base [NSEG];
  int unsigned m_limit[NSEG];
  bit          m_valid[NSEG];
  bit [2:0]    m_perm [NSEG];
  int unsigned m_len;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seg_xlate_unit dut_i (.*);

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string flt_tag(int f);
    case (f)
      0: return "R7";
      1: return "R3 R8";
      2: return "R4 R8";
      3: return "R5 R8";
      default: return "R6 R8";
    endcase
  endfunction

  // one clock: reference model evaluated at the edge, outputs compared mid-cycle
  task automatic step(string scen);
    int ef, ea;
    bit ev, ei;
    @(posedge clk_i);
    ev = req_valid_i; ef = 0; ea = 0;
    if (req_valid_i) begin
      int s = req_seg_i;
      bit pok;
      case (req_acc_i)
        2'd0: pok = m_perm[s][0];
        2'd1: pok = m_perm[s][1];
        2'd2: pok = m_perm[s][2];
        default: pok = 1'b0;
      endcase
      if (s >= m_len) ef = 1;
      else if (!m_valid[s]) ef = 2;
      else if (!pok) ef = 3;
      else if (req_off_i >= m_limit[s]) ef = 4;
      else ea = m_base[s] + req_off_i;
    end
    ei = cfg_we_i && !cfg_priv_i;
    if (cfg_we_i && cfg_priv_i) begin
      if (cfg_len_sel_i) m_len = cfg_len_i;
      else begin
        m_base[cfg_idx_i]  = cfg_base_i;
        m_limit[cfg_idx_i] = cfg_limit_i;
        m_valid[cfg_idx_i] = cfg_valid_i;
        m_perm[cfg_idx_i]  = cfg_perm_i;
      end
    end
    @(negedge clk_i);
    if (ev) begin
      check({scen, " ", flt_tag(ef), " valid R2"}, rsp_valid_o, 1);
      check({scen, " ", flt_tag(ef), " fault"}, rsp_fault_o, ef);
      check({scen, " ", flt_tag(ef), " paddr"}, rsp_paddr_o, ea);
    end else begin
      check({scen, " R2 idle valid"}, rsp_valid_o, 0);
      check({scen, " R2 idle fault/addr"}, {rsp_fault_o, rsp_paddr_o}, 0);
    end
    check({scen, " R10 illegal flag"}, cfg_illegal_o, ei);
  endtask

  task automatic idle_inputs();
    cfg_we_i = 0; req_valid_i = 0;
  endtask

  task automatic wr_ent(bit priv, int idx, int base, int lim, bit v, int perm, bit do_req,
                        int seg, int off, int acc, string scen);
    cfg_we_i = 1; cfg_priv_i = priv; cfg_len_sel_i = 0; cfg_idx_i = 4'(idx);
    cfg_base_i = 16'(base); cfg_limit_i = 13'(lim); cfg_valid_i = v; cfg_perm_i = 3'(perm);
    req_valid_i = do_req; req_seg_i = 4'(seg); req_off_i = 12'(off); req_acc_i = 2'(acc);
    step(scen);
    idle_inputs();
  endtask

  task automatic wr_len(bit priv, int len, string scen);
    cfg_we_i = 1; cfg_priv_i = priv; cfg_len_sel_i = 1; cfg_len_i = 5'(len);
    req_valid_i = 0;
    step(scen);
    idle_inputs();
  endtask

  task automatic xl(int seg, int off, int acc, string scen);
    cfg_we_i = 0; req_valid_i = 1; req_seg_i = 4'(seg); req_off_i = 12'(off); req_acc_i = 2'(acc);
    step(scen);
    idle_inputs();
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 20000) begin
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      m_base[i] = 0; m_limit[i] = 0; m_valid[i] = 0; m_perm[i] = 0;
    end
    m_len = 0;
    repeat (3) @(negedge clk_i);
    // R1: outputs at reset
    check("R1 rsp_valid", rsp_valid_o, 0);
    check("R1 fault/addr", {rsp_fault_o, rsp_paddr_o}, 0);
    check("R1 illegal", cfg_illegal_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    xl(0, 0, 0, "R1 unconfigured");
    xl(15, 5, 2, "R1 unconfigured top");

    // R9 privileged configuration
    wr_len(1, 6, "R9 len");
    wr_ent(1, 0, 'h1000, 'h100, 1, 3'b001, 0, 0, 0, 0, "R9 e0");
    wr_ent(1, 1, 'hFFFF, 'h1000, 1, 3'b111, 0, 0, 0, 0, "R9 e1");
    wr_ent(1, 2, 'h3000, 'h1000, 0, 3'b111, 0, 0, 0, 0, "R9 e2");
    wr_ent(1, 3, 'h4000, 'h0800, 1, 3'b010, 0, 0, 0, 0, "R9 e3");
    wr_ent(1, 4, 'h5000, 'h0000, 1, 3'b100, 0, 0, 0, 0, "R9 e4");

    xl(0, 'hFF, 0, "R7 last byte");
    xl(0, 'h100, 0, "R6 at limit");
    xl(0, 0, 1, "R5 write on read-only");
    xl(0, 0, 3, "R5 reserved access");
    xl(1, 'hFFF, 2, "R7 carry out");
    xl(2, 0, 0, "R4 invalid");
    xl(2, 'hFFF, 3, "R4 outranks access");
    xl(3, 'h7FF, 1, "R7 write ok");
    xl(3, 'h7FF, 0, "R5 read denied");
    xl(4, 0, 2, "R6 zero limit");
    xl(4, 'hFFF, 0, "R5 outranks limit");
    xl(6, 0, 0, "R3 at length");
    xl(7, 0, 0, "R3 outranks invalid");

    // R10 user-mode writes dropped
    wr_len(0, 16, "R10 len drop");
    xl(7, 0, 0, "R10 len unchanged");
    wr_ent(0, 0, 'h0, 'h1000, 1, 3'b111, 0, 0, 0, 0, "R10 ent drop");
    xl(0, 'h10, 0, "R10 entry unchanged");
    xl(0, 'h10, 1, "R10 perms unchanged");

    // R11 same-cycle write uses old contents
    wr_ent(1, 0, 'h2000, 'h200, 1, 3'b011, 1, 0, 'h150, 0, "R11 same cycle");
    xl(0, 'h150, 1, "R11 next cycle R9");
    // back-to-back requests
    cfg_we_i = 0; req_valid_i = 1; req_seg_i = 1; req_off_i = 1; req_acc_i = 0;
    step("R2 b2b a");
    req_seg_i = 3; req_acc_i = 1;
    step("R2 b2b b");
    idle_inputs();
    step("R2 idle");

    wr_len(1, 16, "R9 full len");
    for (int n = 0; n < 400; n++) begin
      cfg_we_i = ($urandom_range(5, 0) == 0);
      cfg_priv_i = ($urandom_range(3, 0) != 0);
      cfg_len_sel_i = ($urandom_range(4, 0) == 0);
      cfg_idx_i = 4'($urandom_range(15, 0));
      cfg_base_i = 16'($urandom);
      cfg_limit_i = 13'($urandom_range(4096, 0));
      cfg_valid_i = ($urandom_range(4, 0) != 0);
      cfg_perm_i = 3'($urandom);
      cfg_len_i = 5'($urandom_range(17, 8));
      req_valid_i = ($urandom_range(3, 0) != 0);
      req_seg_i = 4'($urandom);
      req_off_i = 12'($urandom);
      req_acc_i = 2'($urandom);
      step("R9 R11 random");
    end
    idle_inputs();
    step("R2 final idle");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule